// File: doc/BRIEF.md
# Two-Master Fairness Bus Arbiter

This block shares one bus between two masters. Either master can run locked read-modify-write sequences. The arbiter watches five inputs: the two bus requests, the shared bus-busy line, the lock line of the current owner and that owner's last-access-of-lock marker. It drives one grant per master.

A four-state machine tracks the bus. Two states are steady ownership states, one for each master. The other two are handover states, one for each direction. Ownership moves only when a handover is safe. A locked sequence is never split. The last-access marker lets the owner release the bus while its final locked access is still running, one bus cycle sooner than waiting for the lock line to drop. If the outgoing owner starts a fresh locked cycle while the handover is still pending, the grant goes back to that owner. When nobody else asks for the bus, the current owner keeps it.

Three parameters select variants:
- `EARLY_HANDOVER` chooses whether the last-access marker is honoured.
- `RESET_OWNER` picks the master that owns the bus after reset.
- `ONEHOT_STATE` picks the state register encoding.

Top module: `arb2_fair_arbiter`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the reset owner holds the grant. With `RESET_OWNER`=0 the machine is in OWN1 with m1_gnt=1 and m2_gnt=0. With `RESET_OWNER`=1 it is in OWN2 with m2_gnt=1 and m1_gnt=0.
- R2: Exactly one of m1_gnt and m2_gnt is high in every cycle. Grants are registered and change one clock edge after the inputs that cause the move.
- R3: In OWN1, m2_req=1 with lock_act=0 moves the machine to TO2 on the next edge. TO2 drives m2_gnt=1 and m1_gnt=0.
- R4: With `EARLY_HANDOVER`=1, in OWN1, m2_req=1 with lock_act=1 keeps OWN1 while lock_last=0. When lock_last=1 the machine moves to TO2.
- R5: In TO2, bus_busy=1 together with lock_act=1 returns the machine to OWN1, with m1_gnt=1.
- R6: In TO2, bus_busy=0 moves the machine to OWN2. bus_busy=1 with lock_act=0 holds TO2.
- R7: OWN2 and TO1 mirror OWN1 and TO2 with the masters swapped. m1_req leaves OWN2 under the rules of R3 and R4. In TO1 (m1_gnt=1), bus_busy=0 leads to OWN1, while bus_busy=1 with lock_act=1 leads back to OWN2.
- R8: In an ownership state, if the other master does not request, the owner keeps its grant whatever its own request, busy, lock and last-access inputs are.
- R9: With `EARLY_HANDOVER`=0, lock_last has no effect. A handover request made while lock_act=1 waits until lock_act=0.
- R10: The one-hot and binary state encodings give identical grant sequences for identical inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| m1_req | input | 1 | Bus request from master 1 |
| m2_req | input | 1 | Bus request from master 2 |
| bus_busy | input | 1 | A bus cycle is in progress |
| lock_act | input | 1 | The current owner is in a locked sequence |
| lock_last | input | 1 | The current access is the last one of the locked sequence |
| m1_gnt | output | 1 | Bus grant to master 1 |
| m2_gnt | output | 1 | Bus grant to master 2 |

## Verification
The bench builds two copies side by side and drives them with the same inputs. One copy uses the defaults: early handover on, master 1 as reset owner, binary encoding. The other has early handover off, master 2 as reset owner and a one-hot state register. This pairing covers the lock-release rule, the reset owner and the encoding variant at the same time. A long walk through all 32 input combinations, from every state the walk reaches, compares both copies against an arithmetic model of the transition rules. Directed sequences then pin down the handover, reclaim and parking cases one edge at a time.

// File: rtl/arb2_pkg.sv
package arb2_pkg;

   // Ownership and handover states
   typedef enum logic [1:0] {
      ST_OWN1 = 2'd0,
      ST_TO2  = 2'd1,
      ST_OWN2 = 2'd2,
      ST_TO1  = 2'd3
   } arb_state_e;

   localparam int NUM_STATES = 4;
   localparam int NUM_MASTERS = 2;

   // grant vector: bit 0 = master 1, bit 1 = master 2
   function automatic logic [NUM_MASTERS-1:0] grant_of(arb_state_e s);
      logic [NUM_MASTERS-1:0] g;
      case (s)
         ST_OWN1, ST_TO1: g = 2'b01;
         default:         g = 2'b10;
      endcase
      return g;
   endfunction

   function automatic arb_state_e reset_state(int owner);
      return (owner != 0) ? ST_OWN2 : ST_OWN1;
   endfunction

endpackage

// File: rtl/arb2_release_qual.sv
module arb2_release_qual #(
   parameter int EARLY_HANDOVER = 1
) (
   input  logic lock_act,
   input  logic lock_last,
   output logic may_release
);
   generate
      if (EARLY_HANDOVER != 0) begin : g_early
         // release permitted on the final locked access
         assign may_release = !lock_act || lock_last;
      end else begin : g_late
         logic unused_last;
         assign unused_last = lock_last;
         assign may_release = !lock_act;
      end
   endgenerate
endmodule

// File: rtl/arb2_next_state.sv
module arb2_next_state
   import arb2_pkg::*;
(
   input  arb_state_e cur,
   input  logic       m1_req,
   input  logic       m2_req,
   input  logic       bus_busy,
   input  logic       lock_act,
   input  logic       may_release,
   output arb_state_e nxt
);
   logic new_lock;
   assign new_lock = bus_busy && lock_act;

   always_comb begin
      nxt = cur;
      case (cur)
         ST_OWN1: if (m2_req && may_release) nxt = ST_TO2;
         ST_TO2: begin
            if (new_lock)       nxt = ST_OWN1;
            else if (!bus_busy) nxt = ST_OWN2;
         end
         ST_OWN2: if (m1_req && may_release) nxt = ST_TO1;
         ST_TO1: begin
            if (new_lock)       nxt = ST_OWN2;
            else if (!bus_busy) nxt = ST_OWN1;
         end
         default: nxt = ST_OWN1;
      endcase
   end
endmodule

// File: rtl/arb2_state_reg.sv
module arb2_state_reg
   import arb2_pkg::*;
#(
   parameter int ONEHOT_STATE = 0,
   parameter int RESET_OWNER  = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  arb_state_e nxt,
   output arb_state_e cur
);
   localparam arb_state_e RST_ST = reset_state(RESET_OWNER);

   generate
      if (ONEHOT_STATE != 0) begin : g_onehot
         logic [NUM_STATES-1:0] oh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) oh_q <= NUM_STATES'(1) << RST_ST;
            else        oh_q <= NUM_STATES'(1) << nxt;
         end
         always_comb begin
            cur = ST_OWN1;
            for (int k = 0; k < NUM_STATES; k++)
               if (oh_q[k]) cur = arb_state_e'(2'(k));
         end
      end else begin : g_binary
         arb_state_e st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= RST_ST;
            else        st_q <= nxt;
         end
         assign cur = st_q;
      end
   endgenerate
endmodule

// File: rtl/arb2_grant_reg.sv
module arb2_grant_reg
   import arb2_pkg::*;
#(
   parameter int RESET_OWNER = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  arb_state_e nxt,
   output logic       m1_gnt,
   output logic       m2_gnt
);
   localparam logic [NUM_MASTERS-1:0] RST_GNT = grant_of(reset_state(RESET_OWNER));
   logic [NUM_MASTERS-1:0] gnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnt_q <= RST_GNT;
      else        gnt_q <= grant_of(nxt);
   end

   assign m1_gnt = gnt_q[0];
   assign m2_gnt = gnt_q[1];
endmodule

// File: rtl/arb2_fair_arbiter.sv
module arb2_fair_arbiter
   import arb2_pkg::*;
#(
   parameter int EARLY_HANDOVER = 1,
   parameter int RESET_OWNER    = 0,
   parameter int ONEHOT_STATE   = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic m1_req,
   input  logic m2_req,
   input  logic bus_busy,
   input  logic lock_act,
   input  logic lock_last,
   output logic m1_gnt,
   output logic m2_gnt
);
   generate
      if (EARLY_HANDOVER != 0 && EARLY_HANDOVER != 1) begin : g_bad_early
         $error("EARLY_HANDOVER must be 0 or 1");
      end
      if (RESET_OWNER != 0 && RESET_OWNER != 1) begin : g_bad_owner
         $error("RESET_OWNER must be 0 or 1");
      end
      if (ONEHOT_STATE != 0 && ONEHOT_STATE != 1) begin : g_bad_enc
         $error("ONEHOT_STATE must be 0 or 1");
      end
   endgenerate

   arb_state_e cur_state;
   arb_state_e nxt_state;
   logic       may_release;

   arb2_release_qual #(.EARLY_HANDOVER(EARLY_HANDOVER)) u_rel (
      .lock_act    (lock_act),
      .lock_last   (lock_last),
      .may_release (may_release)
   );

   arb2_next_state u_nxt (
      .cur         (cur_state),
      .m1_req      (m1_req),
      .m2_req      (m2_req),
      .bus_busy    (bus_busy),
      .lock_act    (lock_act),
      .may_release (may_release),
      .nxt         (nxt_state)
   );

   arb2_state_reg #(
      .ONEHOT_STATE (ONEHOT_STATE),
      .RESET_OWNER  (RESET_OWNER)
   ) u_st (
      .clk   (clk),
      .rst_n (rst_n),
      .nxt   (nxt_state),
      .cur   (cur_state)
   );

   arb2_grant_reg #(.RESET_OWNER(RESET_OWNER)) u_gnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .nxt    (nxt_state),
      .m1_gnt (m1_gnt),
      .m2_gnt (m2_gnt)
   );
endmodule

// File: rtl/arb2_fair_arbiter_chk.sv
module arb2_fair_arbiter_chk
   import arb2_pkg::*;
#(
   parameter int EARLY_HANDOVER = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       m1_req,
   input logic       m2_req,
   input logic       bus_busy,
   input logic       lock_act,
   input logic       lock_last,
   input logic       m1_gnt,
   input logic       m2_gnt,
   input arb_state_e cur
);
   p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({m1_gnt, m2_gnt}) == 1);

   // grant decoder agrees with the state register (R1, R10)
   p_grant_map_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == ST_OWN1 || cur == ST_TO1) |-> (m1_gnt && !m2_gnt));

   p_handover_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == ST_OWN1 && m2_req && !lock_act) |=> (cur == ST_TO2));

   p_reclaim_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == ST_TO2 && bus_busy && lock_act) |=> (cur == ST_OWN1));

   p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == ST_TO2 && !bus_busy) |=> (cur == ST_OWN2));

   p_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == ST_TO1 && !bus_busy) |=> (cur == ST_OWN1));

   p_park1_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == ST_OWN1 && !m2_req) |=> (cur == ST_OWN1));

   p_park2_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == ST_OWN2 && !m1_req) |=> (cur == ST_OWN2));

   generate
      if (EARLY_HANDOVER != 0) begin : g_early_chk
         p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cur == ST_OWN1 && lock_act && !lock_last) |=> (cur == ST_OWN1));
      end else begin : g_late_chk
         logic unused_last;
         assign unused_last = lock_last;
         p_no_early_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cur == ST_OWN1 && lock_act) |=> (cur == ST_OWN1));
      end
   endgenerate
endmodule

bind arb2_fair_arbiter arb2_fair_arbiter_chk #(.EARLY_HANDOVER(EARLY_HANDOVER)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .m1_req    (m1_req),
   .m2_req    (m2_req),
   .bus_busy  (bus_busy),
   .lock_act  (lock_act),
   .lock_last (lock_last),
   .m1_gnt    (m1_gnt),
   .m2_gnt    (m2_gnt),
   .cur       (cur_state)
);

// File: tb/sim_arb2_fair_arbiter.sv
module sim_arb2_fair_arbiter;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m1_req = 1'b0, m2_req = 1'b0, bus_busy = 1'b0, lock_act = 1'b0, lock_last = 1'b0;
   logic g1_a, g2_a, g1_b, g2_b;
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   int   ms_a, ms_b;   // model states: 0 OWN1, 1 TO2, 2 OWN2, 3 TO1

   always #10 clk = ~clk;   // 50 MHz

   arb2_fair_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .m1_req(m1_req), .m2_req(m2_req),
      .bus_busy(bus_busy), .lock_act(lock_act), .lock_last(lock_last),
      .m1_gnt(g1_a), .m2_gnt(g2_a));

   arb2_fair_arbiter #(.EARLY_HANDOVER(0), .RESET_OWNER(1), .ONEHOT_STATE(1)) u1 (
      .clk(clk), .rst_n(rst_n), .m1_req(m1_req), .m2_req(m2_req),
      .bus_busy(bus_busy), .lock_act(lock_act), .lock_last(lock_last),
      .m1_gnt(g1_b), .m2_gnt(g2_b));

   function automatic int mnext(int s, bit early, bit r1, bit r2, bit b, bit l, bit le);
      bit rel;
      rel = early ? (!l || le) : !l;
      case (s)
         0: return (r2 && rel) ? 1 : 0;
         1: return (b && l) ? 0 : (!b ? 2 : 1);
         2: return (r1 && rel) ? 3 : 2;
         default: return (b && l) ? 2 : (!b ? 0 : 3);
      endcase
   endfunction

   function automatic logic [1:0] mgnt(int s);
      return (s == 0 || s == 3) ? 2'b01 : 2'b10;
   endfunction

   task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: grants {m2,m1} actual %b expected %b", tag, act, exp);
      end
   endtask

   // drive inputs at a falling edge, sample after the next rising edge
   task automatic step(bit r1, bit r2, bit b, bit l, bit le, string tag);
      m1_req = r1; m2_req = r2; bus_busy = b; lock_act = l; lock_last = le;
      ms_a = mnext(ms_a, 1'b1, r1, r2, b, l, le);
      ms_b = mnext(ms_b, 1'b0, r1, r2, b, l, le);
      @(negedge clk);
      chk({tag, " u0 (R2)"}, {g2_a, g1_a}, mgnt(ms_a));
      chk({tag, " u1 (R10)"}, {g2_b, g1_b}, mgnt(ms_b));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      m1_req = 0; m2_req = 0; bus_busy = 0; lock_act = 0; lock_last = 0;
      repeat (2) @(negedge clk);
      chk("R1 u0 in reset", {g2_a, g1_a}, 2'b01);
      chk("R1 u1 in reset", {g2_b, g1_b}, 2'b10);
      rst_n = 1'b1;
      ms_a = 0; ms_b = 2;
      @(negedge clk);
      chk("R1 u0 after reset", {g2_a, g1_a}, 2'b01);
      chk("R1 u1 after reset", {g2_b, g1_b}, 2'b10);
   endtask

   initial begin
      do_reset();
      // directed sequence on the early-handover copy
      step(0,0,0,0,0, "R8 park idle");      chk("R8 u0", {g2_a,g1_a}, 2'b01);
      step(1,0,1,1,0, "R8 own req");        chk("R8 u0 own", {g2_a,g1_a}, 2'b01);
      step(0,1,1,1,0, "R4 locked hold");    chk("R4 u0 hold", {g2_a,g1_a}, 2'b01);
      step(0,1,1,1,1, "R4 last access");    chk("R4 u0 go", {g2_a,g1_a}, 2'b10);
      step(0,1,1,1,0, "R5 reclaim");        chk("R5 u0", {g2_a,g1_a}, 2'b01);
      step(0,1,1,0,0, "R3 unlocked");       chk("R3 u0", {g2_a,g1_a}, 2'b10);
      step(0,1,1,0,0, "R6 wait busy");      chk("R6 u0 wait", {g2_a,g1_a}, 2'b10);
      step(0,1,0,0,0, "R6 done");           chk("R6 u0 done", {g2_a,g1_a}, 2'b10);
      step(0,0,1,1,1, "R8 park 2");         chk("R8 u0 park2", {g2_a,g1_a}, 2'b10);
      step(1,0,1,1,0, "R7 locked hold");    chk("R7 u0 hold", {g2_a,g1_a}, 2'b10);
      step(1,0,1,1,1, "R7 last access");    chk("R7 u0 go", {g2_a,g1_a}, 2'b01);
      step(1,0,1,1,0, "R7 reclaim");        chk("R7 u0 reclaim", {g2_a,g1_a}, 2'b10);
      step(1,0,1,0,0, "R7 unlocked");       chk("R7 u0 to1", {g2_a,g1_a}, 2'b01);
      step(1,0,0,0,0, "R7 done");           chk("R7 u0 own1", {g2_a,g1_a}, 2'b01);
      step(0,1,1,0,0, "R7 back in own1");   chk("R7 u0 own1 confirm", {g2_a,g1_a}, 2'b10);

      // lock_last ignored on the late-release copy
      do_reset();
      step(1,0,1,1,1, "R9 ignore last");    chk("R9 u1 hold", {g2_b,g1_b}, 2'b10);
      step(1,0,1,1,1, "R9 ignore again");   chk("R9 u1 hold2", {g2_b,g1_b}, 2'b10);
      step(1,0,1,0,0, "R9 lock dropped");   chk("R9 u1 go", {g2_b,g1_b}, 2'b01);
      step(1,0,0,0,0, "R9 done");           chk("R9 u1 own1", {g2_b,g1_b}, 2'b01);

      // near-exhaustive walk through all input combinations
      for (int i = 0; i < 4096; i++) begin
         int c;
         c = (i * 13 + i / 32 + (i / 512) * 5) % 32;
         step(c[4], c[3], c[2], c[1], c[0], "R2 sweep");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule